// File: doc/BRIEF.md
# Segmented Associative Memory Array

This block is a small content-addressable memory. Each entry is 64 bits wide and is made of four 16-bit segments. One global setting divides every entry into two parts. The compared part always starts at segment 0 and covers one to four segments. The remaining upper segments hold associated data that is stored and read back but never compared. A compare presents a 64-bit search word and a validity type. An optional global bit mask can also be applied. The block answers with a hit flag, a flag for more than one hit and the lowest hitting address. Separately, it always reports the lowest entry that is currently empty.

Each entry carries a two-bit validity type. Only entries of the type named by the compare take part in it. A routine filtering compare names the valid type, and a maintenance compare can name any of the other three types. A write can go to an absolute address, to the address of the last compare's hit, or to the next empty entry. A read returns the entry's data and copies its validity type into a status register. The whole array is intended to sit behind a command decoder that sequences these operations.

Top module: `segcam_array`

## Requirements
- R1: The input `cam_segs` = n selects segments 0..n (bits 16*(n+1)-1 down to 0) as the compared part. Bits above that part never affect a compare.
- R2: While `mask_en` is 1, every bit position where `mask_bits` is 1 is excluded from the compare. While `mask_en` is 0, the mask has no effect.
- R3: The validity type is coded as 00 valid, 01 empty, 10 skip and 11 RAM. A compare considers only the entries whose type equals `cmp_type`.
- R4: `match` and `match_addr` are registered on the clock edge where `cmp_req` is 1. `match_addr` is the lowest matching address. Both outputs hold their value until the next compare.
- R5: `multi_match` is registered with `match` and is 1 exactly when two or more entries match.
- R6: `free_addr` is the lowest address whose type is empty, and `free_ok` reports whether any such entry exists. Both follow a change of validity one clock later.
- R7: With `wr_mode` 0, a write stores `wr_data` and `wr_vtype` at `wr_addr`. Mode 3 is ignored.
- R8: With `wr_mode` 1, a write goes to the registered `match_addr`. The write is ignored while `match` is 0.
- R9: With `wr_mode` 2, a write goes to the registered `free_addr`. The write is ignored while `free_ok` is 0.
- R10: A read presents the entry on `rd_data` and its validity type on `rd_status` one clock after `rd_en`.
- R11: Reset is synchronous and active high. It marks every entry empty, clears `match` and `multi_match`, and sets `free_ok` to 1 with `free_addr` 0.
- R12: A compare issued in the same cycle as a write sees the array contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_segs | input | 2 | Index of the highest compared segment |
| mask_en | input | 1 | Apply the global bit mask to compares |
| mask_bits | input | 64 | Global mask, 1 excludes a bit |
| cmp_req | input | 1 | Start a compare |
| cmp_data | input | 64 | Search word |
| cmp_type | input | 2 | Validity type that takes part in the compare |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | 0 absolute, 1 last hit, 2 next free |
| wr_addr | input | 4 | Absolute write address |
| wr_data | input | 64 | Entry data to store |
| wr_vtype | input | 2 | Validity type to store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 64 | Registered read data |
| rd_status | output | 2 | Validity type of the entry last read |
| match | output | 1 | Last compare found a hit |
| multi_match | output | 1 | Last compare found two or more hits |
| match_addr | output | 4 | Lowest hitting address of the last compare |
| free_ok | output | 1 | At least one entry is empty |
| free_addr | output | 4 | Lowest empty address |

## Verification
A write and a compare can land on the same clock edge. In that case the compare must judge the array as it stood before the write. The bench issues an absolute write of a fresh word together with a compare for that same word and expects no hit. A second compare for the word afterwards must hit at the written address. Writes aimed at the last hit or at the next free entry also depend on results registered by earlier cycles. The bench therefore makes such writes right after a compare or a fill that leaves the target invalid, and it confirms through later compares that nothing was stored.

// File: rtl/segcam_pkg.sv
`timescale 1ns/1ps
package segcam_pkg;

  typedef enum logic [1:0] {
    VT_VALID = 2'b00,
    VT_EMPTY = 2'b01,
    VT_SKIP  = 2'b10,
    VT_RAM   = 2'b11
  } vtype_e;

  typedef enum logic [1:0] {
    WM_ABS   = 2'd0,
    WM_MATCH = 2'd1,
    WM_FREE  = 2'd2,
    WM_NONE  = 2'd3
  } wmode_e;

endpackage

// File: rtl/segcam_care.sv
`timescale 1ns/1ps
module segcam_care #(
  parameter int WIDTH = 64,
  parameter int SEG_W = 16,
  localparam int NSEG = WIDTH / SEG_W,
  localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic [SW-1:0]    cam_segs,
  input  logic             mask_en,
  input  logic [WIDTH-1:0] mask_bits,
  output logic [WIDTH-1:0] care
);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic seg_on;
    logic [SEG_W-1:0] seg_mask;
    assign seg_on   = ((SW+1)'(s) <= {1'b0, cam_segs});
    assign seg_mask = mask_en ? mask_bits[s*SEG_W +: SEG_W] : '0;
    assign care[s*SEG_W +: SEG_W] = {SEG_W{seg_on}} & ~seg_mask;
  end

endmodule

// File: rtl/segcam_lane.sv
`timescale 1ns/1ps
module segcam_lane
  import segcam_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] entry,
  input  logic [1:0]       vtype,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] care,
  input  logic [1:0]       sel_type,
  output logic             hit,
  output logic             empty
);

  logic type_ok;
  logic bits_ok;

  assign type_ok = (vtype == sel_type);
  assign bits_ok = (((entry ^ key) & care) == '0);
  assign hit     = type_ok & bits_ok;
  assign empty   = (vtype == VT_EMPTY);

endmodule

// File: rtl/segcam_prio.sv
`timescale 1ns/1ps
module segcam_prio #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] vec,
  output logic             found,
  output logic [AW-1:0]    idx
);

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end

  assign found = |vec;

  // The chosen index is set and no lower index is set (lowest address wins, R4/R6)
  assert_prio_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    found |-> (vec[idx] && ((vec & ((DEPTH'(1) << idx) - DEPTH'(1))) == '0)));

  assert_prio_none_R6: assert property (@(posedge clk) disable iff (rst)
    !found |-> (vec == '0));

endmodule

// File: rtl/segcam_array.sv
`timescale 1ns/1ps
module segcam_array
  import segcam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  parameter int SEG_W = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NSEG = WIDTH / SEG_W,
  localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    cam_segs,
  input  logic             mask_en,
  input  logic [WIDTH-1:0] mask_bits,
  input  logic             cmp_req,
  input  logic [WIDTH-1:0] cmp_data,
  input  logic [1:0]       cmp_type,
  input  logic             wr_en,
  input  logic [1:0]       wr_mode,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       wr_vtype,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic [1:0]       rd_status,
  output logic             match,
  output logic             multi_match,
  output logic [AW-1:0]    match_addr,
  output logic             free_ok,
  output logic [AW-1:0]    free_addr
);

  // Storage: entry data is not reset; validity types are.
  logic [WIDTH-1:0]      mem_q [DEPTH];
  logic [DEPTH-1:0][1:0] vbits_q;

  // Registered results
  logic             match_q, multi_q, free_ok_q;
  logic [AW-1:0]    match_addr_q, free_addr_q;
  logic [WIDTH-1:0] rd_data_q;
  logic [1:0]       rd_status_q;

  // Compare datapath
  logic [WIDTH-1:0] care;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] empty_vec;
  logic             hit_any, free_any;
  logic [AW-1:0]    hit_idx, free_idx;
  logic             hit_multi;

  segcam_care #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_care (
    .cam_segs (cam_segs),
    .mask_en  (mask_en),
    .mask_bits(mask_bits),
    .care     (care)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    segcam_lane #(.WIDTH(WIDTH)) u_lane (
      .entry   (mem_q[g]),
      .vtype   (vbits_q[g]),
      .key     (cmp_data),
      .care    (care),
      .sel_type(cmp_type),
      .hit     (hit_vec[g]),
      .empty   (empty_vec[g])
    );
  end

  segcam_prio #(.DEPTH(DEPTH)) u_hit_prio (
    .clk  (clk),
    .rst  (rst),
    .vec  (hit_vec),
    .found(hit_any),
    .idx  (hit_idx)
  );

  segcam_prio #(.DEPTH(DEPTH)) u_free_prio (
    .clk  (clk),
    .rst  (rst),
    .vec  (empty_vec),
    .found(free_any),
    .idx  (free_idx)
  );

  // Two or more hits: clearing the lowest set bit leaves something behind
  assign hit_multi = ((hit_vec & (hit_vec - DEPTH'(1))) != '0);

  // Write target resolution from registered results of earlier cycles
  logic          wr_go;
  logic [AW-1:0] wr_tgt;

  always_comb begin
    wr_go  = 1'b0;
    wr_tgt = wr_addr;
    case (wr_mode)
      WM_ABS:   begin wr_go = wr_en;             wr_tgt = wr_addr;      end
      WM_MATCH: begin wr_go = wr_en & match_q;   wr_tgt = match_addr_q; end
      WM_FREE:  begin wr_go = wr_en & free_ok_q; wr_tgt = free_addr_q;  end
      default:  begin wr_go = 1'b0;              wr_tgt = wr_addr;      end
    endcase
  end

  // Entry data: single write port, registered read port
  always_ff @(posedge clk) begin
    if (wr_go) mem_q[wr_tgt] <= wr_data;
    if (rd_en) rd_data_q <= mem_q[rd_addr];
  end

  // Validity types and read status
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) vbits_q[i] <= VT_EMPTY;
      rd_status_q <= VT_EMPTY;
    end else begin
      if (wr_go) vbits_q[wr_tgt] <= wr_vtype;
      if (rd_en) rd_status_q <= vbits_q[rd_addr];
    end
  end

  // Compare result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q      <= 1'b0;
      multi_q      <= 1'b0;
      match_addr_q <= '0;
    end else if (cmp_req) begin
      match_q      <= hit_any;
      multi_q      <= hit_multi;
      match_addr_q <= hit_idx;
    end
  end

  // Next-free registers track the validity array every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      free_ok_q   <= 1'b1;
      free_addr_q <= '0;
    end else begin
      free_ok_q   <= free_any;
      free_addr_q <= free_idx;
    end
  end

  assign rd_data     = rd_data_q;
  assign rd_status   = rd_status_q;
  assign match       = match_q;
  assign multi_match = multi_q;
  assign match_addr  = match_addr_q;
  assign free_ok     = free_ok_q;
  assign free_addr   = free_addr_q;

  // ---------------------------------------------------------------- checks
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cmp_req |=> ($stable(match_q) && $stable(multi_q) && $stable(match_addr_q)));

  assert_multi_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
    multi_q |-> match_q);

  assert_status_copy_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_status_q == $past(vbits_q[rd_addr])));

  assert_no_hit_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mode == WM_MATCH && !match_q) |=> $stable(vbits_q));

  assert_full_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mode == WM_FREE && !free_ok_q) |=> $stable(vbits_q));

  assert_reserved_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_mode == WM_NONE) |=> $stable(vbits_q));

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (free_ok_q && free_addr_q == '0 && !match_q && !multi_q));

endmodule

// File: tb/segcam_array_test.sv
`timescale 1ns/1ps
module segcam_array_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cam_segs;
  logic        mask_en;
  logic [63:0] mask_bits;
  logic        cmp_req;
  logic [63:0] cmp_data;
  logic [1:0]  cmp_type;
  logic        wr_en;
  logic [1:0]  wr_mode;
  logic [3:0]  wr_addr;
  logic [63:0] wr_data;
  logic [1:0]  wr_vtype;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic [63:0] rd_data;
  logic [1:0]  rd_status;
  logic        match, multi_match, free_ok;
  logic [3:0]  match_addr, free_addr;

  always #2.5 clk = ~clk;

  segcam_array uut (
    .clk(clk), .rst(rst), .cam_segs(cam_segs), .mask_en(mask_en),
    .mask_bits(mask_bits), .cmp_req(cmp_req), .cmp_data(cmp_data),
    .cmp_type(cmp_type), .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_vtype(wr_vtype), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_status(rd_status), .match(match),
    .multi_match(multi_match), .match_addr(match_addr), .free_ok(free_ok),
    .free_addr(free_addr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Types: 00 valid, 01 empty, 10 skip, 11 RAM. Modes: 0 abs, 1 last hit, 2 next free.
  task automatic do_write(input logic [1:0] mode, input logic [3:0] a,
                          input logic [63:0] d, input logic [1:0] t);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = mode; wr_addr = a; wr_data = d; wr_vtype = t;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_cmp(input logic [1:0] segs, input logic men,
                        input logic [1:0] t, input logic [63:0] d);
    @(negedge clk);
    cam_segs = segs; mask_en = men; cmp_type = t; cmp_data = d; cmp_req = 1'b1;
    @(negedge clk);
    cmp_req = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  segs;
    logic        men;
    logic [1:0]  ty;
    logic [63:0] d;
    logic        m;
    logic        mm;
    logic [3:0]  a;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 2'b00, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 4'd0},
    '{2'd1, 1'b0, 2'b00, 64'h9999_9999_3333_4444, 1'b1, 1'b1, 4'd0},
    '{2'd3, 1'b0, 2'b00, 64'hAAAA_BBBB_3333_4444, 1'b1, 1'b0, 4'd1},
    '{2'd0, 1'b0, 2'b00, 64'hFFFF_FFFF_FFFF_4444, 1'b1, 1'b1, 4'd0},
    '{2'd3, 1'b0, 2'b10, 64'h5555_6666_7777_8888, 1'b1, 1'b0, 4'd2},
    '{2'd3, 1'b0, 2'b11, 64'h5555_6666_7777_8888, 1'b1, 1'b0, 4'd3},
    '{2'd3, 1'b0, 2'b00, 64'h5555_6666_7777_8888, 1'b0, 1'b0, 4'd0},
    '{2'd3, 1'b1, 2'b00, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 4'd4},
    '{2'd3, 1'b0, 2'b00, 64'h0000_0000_0000_0000, 1'b0, 1'b0, 4'd0},
    '{2'd3, 1'b0, 2'b01, 64'h0000_0000_0000_0000, 1'b1, 1'b1, 4'd5}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; cam_segs = 2'd3; mask_en = 1'b0; mask_bits = 64'h0000_0000_0000_00FF;
    cmp_req = 1'b0; cmp_data = '0; cmp_type = 2'b00;
    wr_en = 1'b0; wr_mode = 2'd0; wr_addr = '0; wr_data = '0; wr_vtype = 2'b00;
    rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 match", {63'd0, match}, 64'd0);
    check("R11 multi", {63'd0, multi_match}, 64'd0);
    check("R11 free_ok", {63'd0, free_ok}, 64'd1);
    check("R11 free_addr", {60'd0, free_addr}, 64'd0);

    // Clear every entry to zero data, empty type (R7 absolute writes)
    for (int i = 0; i < 16; i++) do_write(2'd0, 4'(i), 64'd0, 2'b01);
    do_write(2'd0, 4'd0, 64'h1111_2222_3333_4444, 2'b00);
    do_write(2'd0, 4'd1, 64'hAAAA_BBBB_3333_4444, 2'b00);
    do_write(2'd0, 4'd2, 64'h5555_6666_7777_8888, 2'b10);
    do_write(2'd0, 4'd3, 64'h5555_6666_7777_8888, 2'b11);
    do_write(2'd0, 4'd4, 64'h0000_0000_0000_00F0, 2'b00);

    // Vector table: R1 segment width, R2 mask, R3 type, R4 address, R5 multi
    for (int v = 0; v < NV; v++) begin
      do_cmp(VECS[v].segs, VECS[v].men, VECS[v].ty, VECS[v].d);
      check($sformatf("R3/R4 vec%0d match", v), {63'd0, match}, {63'd0, VECS[v].m});
      check($sformatf("R5 vec%0d multi", v), {63'd0, multi_match}, {63'd0, VECS[v].mm});
      if (VECS[v].m)
        check($sformatf("R1/R2/R4 vec%0d addr", v), {60'd0, match_addr}, {60'd0, VECS[v].a});
    end

    // R6 next free after setup
    check("R6 free_ok", {63'd0, free_ok}, 64'd1);
    check("R6 free_addr", {60'd0, free_addr}, 64'd5);

    // R12 compare in the same cycle as a write sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 2'd0; wr_addr = 4'd6; wr_data = 64'hC0DE_0000_1234_5678; wr_vtype = 2'b00;
    cam_segs = 2'd3; mask_en = 1'b0; cmp_type = 2'b00; cmp_data = 64'hC0DE_0000_1234_5678; cmp_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cmp_req = 1'b0;
    check("R12 same-cycle match", {63'd0, match}, 64'd0);
    do_cmp(2'd3, 1'b0, 2'b00, 64'hC0DE_0000_1234_5678);
    check("R7 written match", {63'd0, match}, 64'd1);
    check("R7 written addr", {60'd0, match_addr}, 64'd6);
    // R4 hold across idle cycles
    repeat (3) @(negedge clk);
    check("R4 hold match", {63'd0, match}, 64'd1);
    check("R4 hold addr", {60'd0, match_addr}, 64'd6);
    do_read(4'd6);
    check("R10 read data", rd_data, 64'hC0DE_0000_1234_5678);
    check("R10 read status", {62'd0, rd_status}, 64'd0);

    // R9 write to next free
    do_write(2'd2, 4'd0, 64'hF1F1_0000_0000_0001, 2'b00);
    check("R9 free advanced", {60'd0, free_addr}, 64'd7);
    do_cmp(2'd3, 1'b0, 2'b00, 64'hF1F1_0000_0000_0001);
    check("R9 free write addr", {60'd0, match_addr}, 64'd5);

    // R8 write to last hit
    do_cmp(2'd3, 1'b0, 2'b00, 64'hAAAA_BBBB_3333_4444);
    check("R8 hit addr", {60'd0, match_addr}, 64'd1);
    do_write(2'd1, 4'd0, 64'h7E7E_7E7E_0000_0002, 2'b10);
    do_read(4'd1);
    check("R8 read data", rd_data, 64'h7E7E_7E7E_0000_0002);
    check("R10 read status skip", {62'd0, rd_status}, 64'd2);

    // R8 write ignored without a hit
    do_cmp(2'd3, 1'b0, 2'b00, 64'hDEAD_0000_0000_0001);
    check("R8 no hit", {63'd0, match}, 64'd0);
    do_write(2'd1, 4'd0, 64'hBEEF_0000_0000_0003, 2'b00);
    do_cmp(2'd3, 1'b0, 2'b00, 64'hBEEF_0000_0000_0003);
    check("R8 ignored write", {63'd0, match}, 64'd0);
    check("R8 free unchanged", {60'd0, free_addr}, 64'd7);

    // R9 fill remaining empties, then a free write must be ignored
    for (int i = 0; i < 9; i++) do_write(2'd2, 4'd0, 64'h100 + 64'(i), 2'b10);
    check("R6 full", {63'd0, free_ok}, 64'd0);
    do_write(2'd2, 4'd0, 64'hE0E0_0000_0000_0004, 2'b00);
    do_cmp(2'd3, 1'b0, 2'b00, 64'hE0E0_0000_0000_0004);
    check("R9 ignored when full", {63'd0, match}, 64'd0);
    do_cmp(2'd3, 1'b0, 2'b10, 64'h0000_0000_0000_0108);
    check("R9 last fill addr", {60'd0, match_addr}, 64'd15);

    // R11 reset again from a full array
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R11 free_ok after reset", {63'd0, free_ok}, 64'd1);
    check("R11 free_addr after reset", {60'd0, free_addr}, 64'd0);
    check("R11 match after reset", {63'd0, match}, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule